// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Posting

This block sits between a set of peripheral event sources and a processor core. Any event pulse sets the posted bit of its source, whatever that source's mask bit holds. A posted source takes part in arbitration only while its mask bit is set. Because posting happens before masking, a source that fires while masked is not lost. It is offered to the core as soon as firmware unmasks it.

When the core's global enable is high and at least one source is both posted and unmasked, the controller raises its request. It also presents the vector address of the winning source. The lowest-numbered source wins. Vectors lie on a 4-byte grid above a base address.

The core acknowledges a request with a one-cycle pulse, and that pulse retires the posted bit of the source being vectored. Firmware reaches the mask bits and the posted bits through a small register port, one byte per bank. Writing a posted bank clears bits and also creates software interrupts. An event that arrives in the same cycle as a clear of its bit always leaves the bit posted.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset every mask bit and every posted bit is 0, `irq_o` is 0 and `vec_o` is 0.
- R2: A 1 on `evt_i[i]` in a cycle sets posted bit i at the next clock edge, whether or not mask bit i is set.
- R3: `irq_o` is 1 exactly when `gie_i` is 1 and some source has both its posted bit and its mask bit set. A posted but masked source does not raise `irq_o`.
- R4: Clearing a mask bit leaves the corresponding posted bit set. When the mask bit is set again, that source requests again.
- R5: While `irq_o` is 1, `vec_o` equals VEC_BASE + 4*i, where i is the lowest-numbered source that is posted and unmasked. With the defaults VEC_BASE is 0x0004, so source 0 maps to 0x0004 and source 15 maps to 0x0040.
- R6: While `gie_i` is 0, `irq_o` is 0 and `vec_o` is 0, even when sources are pending.
- R7: An `ack_i` pulse while `irq_o` is 1 clears, at the next edge, only the posted bit of the source shown on `vec_o`. An `ack_i` pulse while `irq_o` is 0 changes nothing.
- R8: Writing bank b of the posted bits (`reg_addr` = 2+b) sets each bit of source 8*b+k whose data bit k is 1, and clears each one whose data bit k is 0. Reading that address returns the posted bits of the bank.
- R9: When a clear by register write or by acknowledge meets a new event for the same source in the same cycle, the bit stays posted.
- R10: Writing `reg_addr` = b (b = 0 or 1) loads the mask bits of sources 8*b to 8*b+7, with a 1 meaning unmasked. Reading that address returns them. Addresses above 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: mask banks at 0..1, posted banks at 2..3 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 1 | Acknowledge pulse from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector address of the winning source |

## Verification
On every cycle, the assertions check four rules. An event always leaves its bit posted, so posting beats any clear. A request never appears without global enable or without a posted, unmasked source. Posted bits never drop unless there is a register write or an accepted acknowledge. An accepted acknowledge retires the vectored source, and vectors stay 4-byte aligned. Only the bench's scenarios can show the exact priority order and vector value for each source position. The same goes for mask read-back, the revival of a masked source after unmasking, and an acknowledge being ignored while the request is low.

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter int REG_W = 8,
  parameter int VEC_W = 16,
  parameter logic [15:0] VEC_BASE = 16'h0004,
  localparam int NSRC = NUM_BANKS * REG_W,
  localparam int ADDR_W = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              gie_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);

  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] mask_q, post_q, pend;
  logic [NSRC-1:0] sw_set, sw_clr, ack_clr, mask_we;
  logic [IDX_W-1:0] win_idx;
  logic win_hit;

  assign pend = post_q & mask_q;

  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign irq_o = gie_i & win_hit;
  assign vec_o = irq_o ? (VEC_W'(VEC_BASE) + (VEC_W'(win_idx) << 2)) : '0;
  assign ack_clr = (ack_i && irq_o) ? (NSRC'(1) << win_idx) : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(b);
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(NUM_BANKS + b);
    wire hit_m = reg_we && (reg_addr == MADDR);
    wire hit_p = reg_we && (reg_addr == PADDR);
    assign mask_we[b*REG_W +: REG_W] = {REG_W{hit_m}};
    assign sw_set[b*REG_W +: REG_W]  = hit_p ? reg_wdata : '0;
    assign sw_clr[b*REG_W +: REG_W]  = hit_p ? ~reg_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      post_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (mask_we[b*REG_W]) mask_q[b*REG_W +: REG_W] <= reg_wdata;
      post_q <= (((post_q & ~sw_clr) | sw_set) & ~ack_clr) | evt_i;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(b)) reg_rdata = mask_q[b*REG_W +: REG_W];
      if (reg_addr == ADDR_W'(NUM_BANKS + b)) reg_rdata = post_q[b*REG_W +: REG_W];
    end
  end

endmodule

// File: rtl/irq_post_ctrl_chk.sv
module irq_post_ctrl_chk #(
  parameter int NSRC = 16,
  parameter int VEC_W = 16,
  parameter logic [15:0] VEC_BASE = 16'h0004
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  evt_i,
  input logic             reg_we,
  input logic             gie_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NSRC-1:0]  mask_q,
  input logic [NSRC-1:0]  post_q
);
  localparam int IDX_W = $clog2(NSRC);
  logic [VEC_W-1:0] rel;
  logic [IDX_W-1:0] ack_idx;
  assign rel = vec_o - VEC_W'(VEC_BASE);
  assign ack_idx = rel[IDX_W+1:2];

  AST_EVT_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((post_q & $past(evt_i)) == $past(evt_i))); // R9

  AST_NO_IRQ_WO_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (!irq_o && vec_o == '0)); // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(post_q & mask_q))); // R3

  AST_POST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !(ack_i && irq_o)) |=> ((post_q & $past(post_q)) == $past(post_q))); // R4

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rel[1:0] == 2'b00 && (rel >> 2) < VEC_W'(NSRC))); // R5

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !reg_we && !evt_i[ack_idx]) |=> !post_q[$past(ack_idx)]); // R7
endmodule

bind irq_post_ctrl irq_post_ctrl_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we), .gie_i(gie_i),
  .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .mask_q(mask_q), .post_q(post_q)
);

// File: tb/test_irq_post_ctrl.sv
module test_irq_post_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic gie_i = 1'b0;
  logic ack_i = 1'b0;
  logic irq_o;
  logic [15:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_post_ctrl i_irq_post_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie_i(gie_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic post16(input logic [15:0] v);
    wr(2'd2, v[7:0]);
    wr(2'd3, v[15:8]);
  endtask

  task automatic chk_post(input string req, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    chk(req, {16'h0, hi, lo}, {16'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    gie_i = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 vec", vec_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 regs", d, 0);
    end

    // R10 mask read-back
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    rd(2'd0, d); chk("R10 mask lo", d, 8'hA5);
    rd(2'd1, d); chk("R10 mask hi", d, 8'h3C);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // R2 / R3: every source posts while masked, no request
    for (int i = 0; i < 16; i++) begin
      evt_i = 16'(1) << i;
      tick();
      evt_i = '0;
      chk_post("R2 post while masked", 16'(1) << i);
      chk("R3 masked no irq", irq_o, 0);
      post16(16'h0000);
    end

    // R5 / R8: exhaustive priority sweep, software-posted
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      post16(16'hFFFF << i);
      chk_post("R8 sw post", 16'hFFFF << i);
      chk("R3 irq", irq_o, 1);
      chk("R5 vec", vec_o, 32'h4 + 32'(4 * i));
    end
    post16(16'h0000);
    chk_post("R8 sw clear", 16'h0000);
    chk("R3 idle", irq_o, 0);

    // R4: mask clear keeps posted bit
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    evt_i = 16'h0008; tick(); evt_i = '0;
    chk("R3 masked", irq_o, 0);
    wr(2'd0, 8'h08);
    chk("R4 unmask irq", irq_o, 1);
    chk("R4 unmask vec", vec_o, 32'h10);
    wr(2'd0, 8'h00);
    chk("R4 remask irq", irq_o, 0);
    chk_post("R4 still posted", 16'h0008);
    wr(2'd0, 8'h08);
    chk("R4 revive", vec_o, 32'h10);

    // R6: global enable gating
    gie_i = 1'b0; #1;
    chk("R6 irq", irq_o, 0);
    chk("R6 vec", vec_o, 0);
    // R7: ack ignored while irq low
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk_post("R7 ack ignored", 16'h0008);
    gie_i = 1'b1;

    // R7: ack retires only the vectored source
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    post16(16'h0124);
    chk("R5 vec src2", vec_o, 32'h0C);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk_post("R7 ack clears one", 16'h0120);
    chk("R7 next vec", vec_o, 32'h18);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk_post("R7 second ack", 16'h0100);
    chk("R7 hi vec", vec_o, 32'h24);

    // R9: event wins against ack and sw clear
    post16(16'h0004);
    ack_i = 1'b1; evt_i = 16'h0004; tick(); ack_i = 1'b0; evt_i = '0;
    chk_post("R9 event beats ack", 16'h0004);
    evt_i = 16'h0004;
    wr(2'd2, 8'h00);
    evt_i = '0;
    chk_post("R9 event beats sw clear", 16'h0004);
    wr(2'd2, 8'h00);
    chk_post("R9 clear alone", 16'h0000);
    chk("R9 idle", irq_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule